// File: doc/BRIEF.md
# Equivalent-Time Sweep Sequencer

This block runs equivalent-time sampling of a repetitive, stationary waveform. A sweep is a sequence of steps. For each step k, the block does four things in order. It shifts a delay code into an external programmable delay line and latches it. It waits a programmable settling time. It then issues one excitation pulse together with a trigger, and the delay line holds that trigger back by the programmed amount before it reaches an external sample-and-hold. Last, it clocks the held value out of a serial converter and writes it into an on-block buffer at address k.

The delay code for step k is k+1, so sample k is taken (k+1) delay steps after the excitation reference. A sweep of N steps therefore rebuilds one period of the signal. The equivalent sample rate is the inverse of the delay step; a 250 ps step, for example, gives 4 Gsample/s from a slow converter. Each step uses a fresh repetition of the excitation, and a new excitation starts only after the previous result has been stored.

The sequencer has nine states:
- **IDLE**: waits for an accepted start.
- **PROG**: starts the code shifter.
- **SHIFT**: waits for the latch.
- **SETTLE**: counts the settling cycles.
- **FIRE**: issues the excitation and trigger for one cycle.
- **CONV_START**: starts the converter read.
- **CONV**: waits for the read to finish.
- **STORE**: writes the buffer.
- **DONE**: issues the completion pulse.

Its transitions are:
- IDLE→PROG on an accepted start.
- PROG→SHIFT.
- SHIFT→SETTLE on the latch.
- SETTLE→FIRE when the count reaches the programmed value.
- FIRE→CONV_START.
- CONV_START→CONV.
- CONV→STORE when the read completes.
- STORE→PROG if more steps remain.
- STORE→DONE after the last step.
- DONE→IDLE.

Top module: `ets_sweep_seq`

## Requirements
- R1: While reset is held, excite, sh_trig, dl_sclk, dl_latch, adc_sclk, done_pulse and sweep_done are 0, and adc_cs_n is 1.
- R2: Before step k (counting from 0), the block shifts the CODE_W-bit code k+1 onto dl_sdata, most significant bit first. Each bit is valid while dl_sclk is high. A one-cycle dl_latch pulse follows the last bit. Steps run in increasing order 0..N-1.
- R3: excite rises exactly settle_cycles+2 clock cycles after the cycle in which dl_latch is high.
- R4: excite and sh_trig are high together for exactly one cycle per step, so a sweep of N steps gives exactly N such pulses.
- R5: After each trigger, adc_cs_n goes low and ADC_W dl-independent adc_sclk pulses are issued. adc_sdo is captured on each falling edge of adc_sclk, most significant bit first. The resulting word is readable on rd_data at rd_addr = k once the sweep is done.
- R6: While excite is high, adc_cs_n is high and neither dl_sclk nor dl_latch is active. Each conversion frame starts two cycles after a trigger.
- R7: A sweep runs step_count steps. When it ends, done_pulse is high for one cycle and sweep_done is high from the next cycle. sweep_done stays high until the next accepted start, which clears it in the following cycle.
- R8: A sweep_go with step_count equal to 0, or greater than 2**ADDR_W, is ignored. No excitation follows and sweep_done keeps its value.
- R9: step_count and settle_cycles are captured at an accepted start. sweep_go and changes of those inputs during a sweep have no effect on that sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sweep_go | input | 1 | Start request, one cycle |
| step_count | input | ADDR_W+1 | Steps per sweep (1..2**ADDR_W) |
| settle_cycles | input | SETTLE_W | Extra settling cycles after the latch |
| excite | output | 1 | Excitation pulse |
| sh_trig | output | 1 | Trigger to the delay line and sample-and-hold |
| dl_sclk | output | 1 | Delay-code shift clock |
| dl_sdata | output | 1 | Delay-code serial data |
| dl_latch | output | 1 | Delay-code latch strobe |
| adc_cs_n | output | 1 | Converter frame select, active low |
| adc_sclk | output | 1 | Converter shift clock |
| adc_sdo | input | 1 | Converter serial data |
| rd_addr | input | ADDR_W | Buffer read address |
| rd_data | output | ADC_W | Buffer word at rd_addr |
| sweep_done | output | 1 | Sweep completed flag |
| done_pulse | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume the converter holds adc_sdo steady from one falling edge of adc_sclk to the next. They also assume sweep_go is a single-cycle request and CODE_W exceeds ADDR_W, so that the code N fits. The bench's converter model changes adc_sdo only after the block's edges: once when the frame opens and once after each falling adc_sclk. The bench drives sweep_go for exactly one cycle, including when it deliberately issues starts during a busy sweep or with out-of-range step counts.

// File: rtl/ets_pkg.sv
package ets_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PROG,
        S_SHIFT,
        S_SETTLE,
        S_FIRE,
        S_CONV_START,
        S_CONV,
        S_STORE,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_LOW,
        SH_HIGH,
        SH_LATCH
    } shift_state_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_LOW,
        RD_HIGH,
        RD_END
    } read_state_t;

endpackage

// File: rtl/ets_code_shifter.sv
module ets_code_shifter
    import ets_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_latch,
    output logic              done
);
    localparam int CW = $clog2(CODE_W + 1);

    shift_state_t      st_q, st_d;
    logic [CODE_W-1:0] sh_q;
    logic [CW-1:0]     cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SH_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SH_IDLE:  if (start) st_d = SH_LOW;
            SH_LOW:   st_d = SH_HIGH;
            SH_HIGH:  st_d = (cnt_q == CW'(1)) ? SH_LATCH : SH_LOW;
            SH_LATCH: st_d = SH_IDLE;
            default:  st_d = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (st_q == SH_IDLE && start) begin
            sh_q  <= code;
            cnt_q <= CW'(CODE_W);
        end else if (st_q == SH_HIGH) begin
            sh_q  <= sh_q << 1;
            cnt_q <= cnt_q - CW'(1);
        end
    end

    always_comb begin
        ser_clk   = (st_q == SH_HIGH);
        ser_data  = (st_q == SH_LOW || st_q == SH_HIGH) ? sh_q[CODE_W-1] : 1'b0;
        ser_latch = (st_q == SH_LATCH);
        done      = (st_q == SH_LATCH);
    end

    // R2: the latch strobe directly follows the final bit clock
    assert_latch_after_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ser_latch |-> $past(ser_clk));

endmodule

// File: rtl/ets_adc_reader.sv
module ets_adc_reader
    import ets_pkg::*;
#(
    parameter int ADC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sdo,
    output logic             cs_n,
    output logic             sclk,
    output logic [ADC_W-1:0] result,
    output logic             done
);
    localparam int CW = $clog2(ADC_W + 1);

    read_state_t      st_q, st_d;
    logic [ADC_W-1:0] sh_q;
    logic [CW-1:0]    cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RD_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RD_IDLE: if (start) st_d = RD_LOW;
            RD_LOW:  st_d = RD_HIGH;
            RD_HIGH: st_d = (cnt_q == CW'(1)) ? RD_END : RD_LOW;
            RD_END:  st_d = RD_IDLE;
            default: st_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (st_q == RD_IDLE && start) begin
            cnt_q <= CW'(ADC_W);
        end else if (st_q == RD_HIGH) begin
            sh_q  <= {sh_q[ADC_W-2:0], sdo};
            cnt_q <= cnt_q - CW'(1);
        end
    end

    always_comb begin
        cs_n   = !(st_q == RD_LOW || st_q == RD_HIGH);
        sclk   = (st_q == RD_HIGH);
        done   = (st_q == RD_END);
        result = sh_q;
    end

    // R5: completion only follows a final falling shift clock
    assert_done_after_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(sclk));

endmodule

// File: rtl/ets_sample_ram.sv
module ets_sample_ram #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ets_sweep_seq.sv
module ets_sweep_seq
    import ets_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int CODE_W   = 8,
    parameter int ADC_W    = 12,
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sweep_go,
    input  logic [ADDR_W:0]     step_count,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic                excite,
    output logic                sh_trig,
    output logic                dl_sclk,
    output logic                dl_sdata,
    output logic                dl_latch,
    output logic                adc_cs_n,
    output logic                adc_sclk,
    input  logic                adc_sdo,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [ADC_W-1:0]    rd_data,
    output logic                sweep_done,
    output logic                done_pulse
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NW    = ADDR_W + 1;

    seq_state_t          st_q, st_d;
    logic [ADDR_W-1:0]   step_q, last_q;
    logic [SETTLE_W-1:0] settle_q, wait_q;
    logic                done_q;
    logic                go_ok;
    logic                ld_start, ld_done, adc_start, adc_done, wr_en;
    logic [CODE_W-1:0]   code;
    logic [ADC_W-1:0]    adc_word;

    assign go_ok = sweep_go && (step_count != '0) && (step_count <= NW'(DEPTH));
    assign code  = CODE_W'({1'b0, step_q}) + CODE_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:       if (go_ok) st_d = S_PROG;
            S_PROG:       st_d = S_SHIFT;
            S_SHIFT:      if (ld_done) st_d = S_SETTLE;
            S_SETTLE:     if (wait_q == settle_q) st_d = S_FIRE;
            S_FIRE:       st_d = S_CONV_START;
            S_CONV_START: st_d = S_CONV;
            S_CONV:       if (adc_done) st_d = S_STORE;
            S_STORE:      st_d = (step_q == last_q) ? S_DONE : S_PROG;
            S_DONE:       st_d = S_IDLE;
            default:      st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= '0;
            last_q   <= '0;
            settle_q <= '0;
            wait_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            unique case (st_q)
                S_IDLE: if (go_ok) begin
                    step_q   <= '0;
                    last_q   <= ADDR_W'(step_count - NW'(1));
                    settle_q <= settle_cycles;
                    done_q   <= 1'b0;
                end
                S_SHIFT:  wait_q <= '0;
                S_SETTLE: wait_q <= wait_q + SETTLE_W'(1);
                S_STORE:  if (step_q != last_q) step_q <= step_q + ADDR_W'(1);
                S_DONE:   done_q <= 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        excite     = (st_q == S_FIRE);
        sh_trig    = (st_q == S_FIRE);
        ld_start   = (st_q == S_PROG);
        adc_start  = (st_q == S_CONV_START);
        wr_en      = (st_q == S_STORE);
        done_pulse = (st_q == S_DONE);
        sweep_done = done_q;
    end

    ets_code_shifter #(.CODE_W(CODE_W)) shifter_i (
        .clk(clk), .rst_n(rst_n), .start(ld_start), .code(code),
        .ser_clk(dl_sclk), .ser_data(dl_sdata), .ser_latch(dl_latch), .done(ld_done)
    );

    ets_adc_reader #(.ADC_W(ADC_W)) reader_i (
        .clk(clk), .rst_n(rst_n), .start(adc_start), .sdo(adc_sdo),
        .cs_n(adc_cs_n), .sclk(adc_sclk), .result(adc_word), .done(adc_done)
    );

    ets_sample_ram #(.ADDR_W(ADDR_W), .DATA_W(ADC_W)) ram_i (
        .clk(clk), .wr_en(wr_en), .wr_addr(step_q), .wr_data(adc_word),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assert_fire_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        excite |=> !excite);

    assert_fire_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        excite |-> (adc_cs_n && !dl_sclk && !dl_latch));

    assert_frame_after_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> $past(excite, 2));

    assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> (sweep_done && !done_pulse));

endmodule

// File: tb/ets_sweep_seq_tb_top.sv
module ets_sweep_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 5;
    localparam int CODE_W = 8;
    localparam int ADC_W = 12;
    localparam int SETTLE_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sweep_go = 1'b0;
    logic [ADDR_W:0] step_count = '0;
    logic [SETTLE_W-1:0] settle_cycles = '0;
    logic excite, sh_trig, dl_sclk, dl_sdata, dl_latch, adc_cs_n, adc_sclk;
    logic adc_sdo = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [ADC_W-1:0] rd_data;
    logic sweep_done, done_pulse;

    always #(CLK_PERIOD/2) clk = ~clk;

    ets_sweep_seq #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .ADC_W(ADC_W), .SETTLE_W(SETTLE_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sweep_go(sweep_go), .step_count(step_count),
        .settle_cycles(settle_cycles), .excite(excite), .sh_trig(sh_trig),
        .dl_sclk(dl_sclk), .dl_sdata(dl_sdata), .dl_latch(dl_latch),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdo(adc_sdo),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .sweep_done(sweep_done), .done_pulse(done_pulse)
    );

    int checks = 0;
    int failures = 0;
    int sweep_id = 0;
    int cur_settle = 0;
    int fire_cnt = 0;
    int cyc = 0;
    int latch_cyc = 0;
    bit finished = 0;
    int exp_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [ADC_W-1:0] sample_val(input int code);
        return ADC_W'((code * 149 + sweep_id * 23 + 7) & 12'hFFF);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: decodes the delay code, checks trigger timing, models the converter
    logic [CODE_W-1:0] code_sh = '0;
    int last_code = 0;
    logic p_dl = 1'b0, p_cs = 1'b1, p_as = 1'b0;
    logic [ADC_W-1:0] adc_word = '0;
    int adc_bit = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (dl_sclk && !p_dl) code_sh = {code_sh[CODE_W-2:0], dl_sdata};
            if (dl_latch) begin
                if (exp_q.size() == 0) check(0, "R2 unexpected latch", int'(code_sh), 0);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(code_sh) == e, "R2 delay code", int'(code_sh), e);
                end
                last_code = int'(code_sh);
                latch_cyc = cyc;
            end
            if (excite) begin
                fire_cnt++;
                check(sh_trig == 1'b1, "R4 trigger with excite", int'(sh_trig), 1);
                check(cyc - latch_cyc == cur_settle + 2, "R3 settle delay", cyc - latch_cyc, cur_settle + 2);
            end
            if (!adc_cs_n && p_cs) begin
                adc_word = sample_val(last_code);
                adc_bit = ADC_W - 1;
                adc_sdo = adc_word[adc_bit];
            end else if (!adc_sclk && p_as) begin
                if (adc_bit > 0) adc_bit--;
                adc_sdo = adc_word[adc_bit];
            end
        end
        p_dl = dl_sclk;
        p_cs = adc_cs_n;
        p_as = adc_sclk;
    end

    // Driver: pushes the expected codes, starts the sweep, checks completion and buffer
    task automatic run_sweep(input int n, input int settle, input bit disturb);
        int f0;
        bit seen;
        sweep_id++;
        for (int k = 0; k < n; k++) exp_q.push_back(k + 1);
        cur_settle = settle;
        f0 = fire_cnt;
        @(negedge clk);
        step_count = (ADDR_W+1)'(n);
        settle_cycles = SETTLE_W'(settle);
        sweep_go = 1'b1;
        @(negedge clk);
        sweep_go = 1'b0;
        check(sweep_done == 1'b0, "R7 done cleared by start", int'(sweep_done), 0);
        if (disturb) begin
            repeat (30) @(negedge clk);
            step_count = 3;
            settle_cycles = 1;
            sweep_go = 1'b1;
            @(negedge clk);
            sweep_go = 1'b0;
        end
        seen = 0;
        for (int t = 0; t < 20000 && !seen; t++) begin
            @(negedge clk);
            if (done_pulse) seen = 1;
        end
        check(seen, "R7 done pulse seen", int'(seen), 1);
        @(negedge clk);
        check(sweep_done == 1'b1 && done_pulse == 1'b0, "R7 done flag after pulse",
              int'(sweep_done), 1);
        check(fire_cnt - f0 == n, disturb ? "R9 excite count unchanged by busy start" : "R4 excite count",
              fire_cnt - f0, n);
        check(exp_q.size() == 0, "R2 all codes issued", exp_q.size(), 0);
        for (int a = 0; a < n; a++) begin
            rd_addr = ADDR_W'(a);
            #1;
            check(rd_data == sample_val(a + 1), "R5 stored sample", int'(rd_data), int'(sample_val(a + 1)));
        end
    endtask

    task automatic try_ignored(input int n);
        int f0;
        f0 = fire_cnt;
        @(negedge clk);
        step_count = (ADDR_W+1)'(n);
        sweep_go = 1'b1;
        @(negedge clk);
        sweep_go = 1'b0;
        repeat (60) @(negedge clk);
        check(fire_cnt == f0, "R8 rejected start gives no excite", fire_cnt - f0, 0);
        check(sweep_done == 1'b1, "R8 done flag kept", int'(sweep_done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!excite && !sh_trig && !dl_sclk && !dl_latch && !adc_sclk, "R1 idle outputs",
              int'({excite, sh_trig, dl_sclk, dl_latch, adc_sclk}), 0);
        check(adc_cs_n == 1'b1, "R1 converter deselected", int'(adc_cs_n), 1);
        check(!sweep_done && !done_pulse, "R1 no completion", int'({sweep_done, done_pulse}), 0);
        rst_n = 1'b1;
        run_sweep(5, 3, 1'b1);
        try_ignored(0);
        try_ignored(33);
        run_sweep(32, 0, 1'b0);
        run_sweep(1, 7, 1'b0);
        run_sweep(9, 2, 1'b0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

endmodule